// File: doc/BRIEF.md
# Byte-Wide Timer and Interrupt Register File

This block is a sixteen-entry, byte-wide register file for a general-purpose parallel interface with timers. A processor reaches it through a simple read and write strobe pair. The register is chosen by a four-bit field of the address bus. Reads return data combinationally from the current state. Their side effects, and all write effects, take hold at the next rising clock edge.

Two timers run from a shared prescaled tick enable. The first timer is a sixteen-bit down counter with a reload latch. When it leaves the all-ones state it reloads from the latch, so one period is the latch value plus two ticks. It raises its flag only in the continuous-interrupt mode. The second timer is a sixteen-bit down counter with no reload, and it flags once per load. A shift data byte is also held here. Its flag is raised by an external strobe, since the serial shifter itself sits elsewhere.

The flag register, the enable register and one interrupt output gather the three event sources. Only the first timer and the shift event can drive the interrupt pin. The port data, direction and control registers are plain storage.

Top module: `vtimer_regfile`

## Requirements
- R1: The register index is address bits [12:9], and all other address bits are ignored. Indices 0, 1, 2, 3, 11, 12 and 15 are plain byte storage that reads back what was written. Index 11 is the mode byte for timer 1.
- R2: On each tick, timer 1 decrements. From 0xFFFF it reloads the 16-bit latch, so a latch value L repeats every L+2 ticks.
- R3: Flag bit 6 is set by the tick that brings timer 1 to zero, and only while index 11 bits [7:6] equal 01. In any other mode the flag is not set, although the counter still runs.
- R4: A write to index 5 sets latch bits [15:8], loads the whole latch into timer 1 and clears flag bit 6. A write to index 4 or 6 sets only latch bits [7:0]. A write to index 7 sets latch bits [15:8] and clears flag bit 6, and leaves the counter unchanged.
- R5: A read of index 4 returns counter bits [7:0] and clears flag bit 6. A read of index 5 returns counter bits [15:8] and clears nothing. Indices 6 and 7 read the latch bytes.
- R6: A write to index 8 stores the low load byte of timer 2. A write to index 9 loads timer 2 with {data, low load byte} and arms it. Each tick decrements timer 2, wrapping from 0 to 0xFFFF. Flag bit 5 is set once, when an armed timer 2 reaches zero. Indices 8 and 9 read the count bytes, and a read of index 8 clears flag bit 5.
- R7: Index 10 stores a shift data byte. A pulse on the shift strobe input sets flag bit 2. A read of index 10 returns the byte and clears flag bit 2.
- R8: A write to index 13 clears every flag bit written as 1. A read of index 13 returns flags [6:0], with bit 7 set when any flag is both set and enabled.
- R9: A write to index 14 with data bit 7 set ORs data bits [6:0] into the enable register. With data bit 7 clear, it clears the enable bits written as 1. A read of index 14 returns the enable register with bit 7 forced to 1.
- R10: The interrupt output is high exactly when flag bit 6 or flag bit 2 is set together with its enable bit. Flag bit 5 never drives the pin.
- R11: After reset, the timer 1 latch and counter are 0xFFFF, the timer 2 counter is 0xFFFF with a low load byte of 0, and all flags and enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Byte address; bits [12:9] select the register |
| wr_en_i | input | 1 | Write strobe for one cycle |
| rd_en_i | input | 1 | Read strobe for one cycle; applies the read side effects |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register (combinational) |
| tick_i | input | 1 | Prescaled count enable for both timers |
| shift_strobe_i | input | 1 | Sets the shift event flag |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A wrong timer 1 count or reload value shows up in the bytes read from indices 4 and 5. It also moves the cycle in which flag bit 6 and the interrupt pin rise, so the error is seen within one timer period of latch+2 ticks. A flag that is lost, stuck, or cleared by the wrong access shows in the next read of index 13, and in the pin level one cycle after the event. A wrong enable update is seen both in the index 14 readback and in the summary bit of index 13. Timer 2 errors show in the count bytes, and in whether flag bit 5 appears once, twice or never.

// File: rtl/vtimer_pkg.sv
package vtimer_pkg;

   // Register indices within the 16-entry map
   localparam logic [3:0] IDX_PB    = 4'd0;
   localparam logic [3:0] IDX_PA    = 4'd1;
   localparam logic [3:0] IDX_DB    = 4'd2;
   localparam logic [3:0] IDX_DA    = 4'd3;
   localparam logic [3:0] IDX_C1LO  = 4'd4;
   localparam logic [3:0] IDX_C1HI  = 4'd5;
   localparam logic [3:0] IDX_L1LO  = 4'd6;
   localparam logic [3:0] IDX_L1HI  = 4'd7;
   localparam logic [3:0] IDX_C2LO  = 4'd8;
   localparam logic [3:0] IDX_C2HI  = 4'd9;
   localparam logic [3:0] IDX_SHF   = 4'd10;
   localparam logic [3:0] IDX_MODE  = 4'd11;
   localparam logic [3:0] IDX_PCTL  = 4'd12;
   localparam logic [3:0] IDX_FLG   = 4'd13;
   localparam logic [3:0] IDX_ENA   = 4'd14;
   localparam logic [3:0] IDX_PANH  = 4'd15;

   // Flag bit positions
   localparam int FLG_T1  = 6;
   localparam int FLG_T2  = 5;
   localparam int FLG_SHF = 2;

   // Indices backed by plain storage
   localparam logic [15:0] PLAIN_MASK = 16'b1001_1100_0000_1111;

   // Mode field value that allows timer 1 events
   localparam logic [1:0] T1_CONT = 2'b01;

endpackage

// File: rtl/vtimer_t1.sv
module vtimer_t1 #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              cont_i,
   input  logic              lat_lo_we_i,
   input  logic              lat_hi_we_i,
   input  logic              load_we_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  latch_o,
   output logic              hit_o
);

   logic [CNT_W-1:0] cnt_q, latch_q, nxt;

   // counts through all-ones before reloading
   always_comb nxt = (cnt_q == '1) ? latch_q : cnt_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         latch_q <= '1;
      end else begin
         if (lat_lo_we_i) latch_q[BYTE_W-1:0]     <= wdata_i;
         if (lat_hi_we_i) latch_q[CNT_W-1:BYTE_W] <= wdata_i;
         if (load_we_i)   cnt_q <= {wdata_i, latch_q[BYTE_W-1:0]};
         else if (tick_i) cnt_q <= nxt;
      end
   end

   assign hit_o   = tick_i && !load_we_i && cont_i && (nxt == '0);
   assign cnt_o   = cnt_q;
   assign latch_o = latch_q;

   // R2
   t1_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_we_i && cnt_q == '1) |=> cnt_q == $past(latch_q));
   // R2
   t1_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_we_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) - 1'b1);
   // R4
   t1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_we_i) |=> $stable(cnt_q));

endmodule

// File: rtl/vtimer_t2.sv
module vtimer_t2 #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              lo_we_i,
   input  logic              hi_we_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              hit_o
);

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] lo_q;
   logic              armed_q;

   assign hit_o = tick_i && !hi_we_i && armed_q && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         lo_q    <= '0;
         armed_q <= 1'b0;
      end else begin
         if (lo_we_i) lo_q <= wdata_i;
         if (hi_we_i) begin
            cnt_q   <= {wdata_i, lo_q};
            armed_q <= 1'b1;
         end else if (tick_i) begin
            cnt_q <= cnt_q - 1'b1;
            if (hit_o) armed_q <= 1'b0;
         end
      end
   end

   assign cnt_o = cnt_q;

   // R6
   t2_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !hi_we_i && cnt_q == '0) |=> cnt_q == '1);
   // R6
   t2_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !armed_q);

endmodule

// File: rtl/vtimer_irq.sv
module vtimer_irq #(
   parameter int          FLG_W    = 7,
   parameter logic [6:0]  IRQ_MASK = 7'h44
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLG_W-1:0] set_i,
   input  logic [FLG_W-1:0] clr_i,
   input  logic             ena_we_i,
   input  logic [FLG_W:0]   wdata_i,
   output logic [FLG_W-1:0] flags_o,
   output logic [FLG_W-1:0] ena_o,
   output logic             irq_o
);

   logic [FLG_W-1:0] flags_q, ena_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         ena_q   <= '0;
      end else begin
         // a new event wins over a clear in the same cycle
         flags_q <= (flags_q & ~clr_i) | set_i;
         if (ena_we_i) begin
            if (wdata_i[FLG_W]) ena_q <= ena_q | wdata_i[FLG_W-1:0];
            else                ena_q <= ena_q & ~wdata_i[FLG_W-1:0];
         end
      end
   end

   assign flags_o = flags_q;
   assign ena_o   = ena_q;
   assign irq_o   = |(flags_q & ena_q & IRQ_MASK);

   // R10
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ena_q & IRQ_MASK) == '0) |-> !irq_o);
   // R8
   flg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));
   // R9
   ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_we_i && wdata_i[FLG_W]) |=> ((ena_q & $past(wdata_i[FLG_W-1:0])) == $past(wdata_i[FLG_W-1:0])));

endmodule

// File: rtl/vtimer_regfile.sv
module vtimer_regfile
   import vtimer_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int SEL_LSB = 9,
   parameter int SEL_W   = 4,
   parameter int BYTE_W  = 8,
   parameter int CNT_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   input  logic              tick_i,
   input  logic              shift_strobe_i,
   output logic              irq_o
);

   localparam int NREG  = 1 << SEL_W;
   localparam int FLG_W = BYTE_W - 1;
   localparam logic [FLG_W-1:0] IRQ_MASK = FLG_W'((1 << FLG_T1) | (1 << FLG_SHF));

   initial begin
      cfg_byte_chk: assert (BYTE_W == 8) else $error("byte width must be 8");
      cfg_cnt_chk:  assert (CNT_W == 2 * BYTE_W) else $error("counter must be two bytes");
      cfg_sel_chk:  assert (SEL_W == 4 && SEL_LSB > 0 && SEL_LSB + SEL_W < ADDR_W)
         else $error("select field must fit inside the address");
   end

   logic [SEL_W-1:0] sel;
   logic             unused_addr;
   assign sel         = addr_i[SEL_LSB +: SEL_W];
   assign unused_addr = ^{addr_i[SEL_LSB-1:0], addr_i[ADDR_W-1:SEL_LSB+SEL_W]};

   logic wr, rd;
   assign wr = wr_en_i;
   assign rd = rd_en_i;

   // ---------------- plain storage ----------------
   logic [BYTE_W-1:0] plain_q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_store
      if (PLAIN_MASK[g]) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               plain_q[g] <= '0;
            else if (wr && sel == SEL_W'(g))          plain_q[g] <= wdata_i;
         end
      end else begin : g_none
         assign plain_q[g] = '0;
      end
   end

   // ---------------- timers ----------------
   logic [CNT_W-1:0] t1_cnt, t1_latch, t2_cnt;
   logic             t1_hit, t2_hit, t1_cont;

   assign t1_cont = (plain_q[IDX_MODE][BYTE_W-1 -: 2] == T1_CONT);

   vtimer_t1 #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) t1_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .cont_i     (t1_cont),
      .lat_lo_we_i(wr && (sel == IDX_C1LO || sel == IDX_L1LO)),
      .lat_hi_we_i(wr && (sel == IDX_C1HI || sel == IDX_L1HI)),
      .load_we_i  (wr && sel == IDX_C1HI),
      .wdata_i    (wdata_i),
      .cnt_o      (t1_cnt),
      .latch_o    (t1_latch),
      .hit_o      (t1_hit)
   );

   vtimer_t2 #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) t2_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .lo_we_i (wr && sel == IDX_C2LO),
      .hi_we_i (wr && sel == IDX_C2HI),
      .wdata_i (wdata_i),
      .cnt_o   (t2_cnt),
      .hit_o   (t2_hit)
   );

   // ---------------- flags and enables ----------------
   logic [FLG_W-1:0] flg_set, flg_clr, flags, ena;

   always_comb begin
      flg_set          = '0;
      flg_set[FLG_T1]  = t1_hit;
      flg_set[FLG_T2]  = t2_hit;
      flg_set[FLG_SHF] = shift_strobe_i;

      flg_clr = '0;
      if (wr && sel == IDX_FLG)                        flg_clr = wdata_i[FLG_W-1:0];
      if (wr && (sel == IDX_C1HI || sel == IDX_L1HI))  flg_clr[FLG_T1]  = 1'b1;
      if (rd && sel == IDX_C1LO)                       flg_clr[FLG_T1]  = 1'b1;
      if (rd && sel == IDX_C2LO)                       flg_clr[FLG_T2]  = 1'b1;
      if (rd && sel == IDX_SHF)                        flg_clr[FLG_SHF] = 1'b1;
   end

   vtimer_irq #(.FLG_W(FLG_W), .IRQ_MASK(IRQ_MASK)) irq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (flg_set),
      .clr_i   (flg_clr),
      .ena_we_i(wr && sel == IDX_ENA),
      .wdata_i (wdata_i),
      .flags_o (flags),
      .ena_o   (ena),
      .irq_o   (irq_o)
   );

   // ---------------- read mux ----------------
   always_comb begin
      case (sel)
         IDX_C1LO: rdata_o = t1_cnt[BYTE_W-1:0];
         IDX_C1HI: rdata_o = t1_cnt[CNT_W-1:BYTE_W];
         IDX_L1LO: rdata_o = t1_latch[BYTE_W-1:0];
         IDX_L1HI: rdata_o = t1_latch[CNT_W-1:BYTE_W];
         IDX_C2LO: rdata_o = t2_cnt[BYTE_W-1:0];
         IDX_C2HI: rdata_o = t2_cnt[CNT_W-1:BYTE_W];
         IDX_FLG:  rdata_o = {|(flags & ena), flags};
         IDX_ENA:  rdata_o = {1'b1, ena};
         default:  rdata_o = plain_q[sel];
      endcase
   end

   // R3
   t1_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[FLG_T1] && !t1_cont) |=> !flags[FLG_T1]);
   // R9
   ena_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == IDX_ENA) |-> rdata_o[BYTE_W-1]);
   // R10
   t2_noirq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[FLG_T1] && !flags[FLG_SHF]) |-> !irq_o);

endmodule

// File: tb/vtimer_regfile_tb_top.sv
module vtimer_regfile_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        tick = 1'b0, strobe = 1'b0;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vtimer_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .shift_strobe_i(strobe),
      .irq_o(irq)
   );

   // unused address bits carry a fixed noise pattern
   function automatic logic [15:0] mk_addr(input logic [3:0] idx);
      return {3'b101, idx, 9'h0A5};
   endfunction

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;

   function automatic logic [25:0] mk(input int req, input logic [1:0] op,
                                      input logic [3:0] idx, input logic [7:0] d,
                                      input logic [7:0] e);
      return {4'(req), op, idx, d, e};
   endfunction

   localparam int NVEC = 34;
   localparam logic [25:0] VEC [NVEC] = '{
      mk(3, OP_WR, 11, 8'h40, 0),   // R3 continuous mode
      mk(4, OP_WR,  6, 8'h03, 0),   // R4 latch low
      mk(4, OP_WR,  5, 8'h00, 0),   // R4 load 0x0003
      mk(5, OP_RD,  4, 0, 8'h03),   // R5
      mk(5, OP_RD,  5, 0, 8'h00),   // R5
      mk(2, OP_TK,  0, 3, 0),       // R2 reach zero
      mk(3, OP_RD, 13, 0, 8'h40),   // R3 flag set
      mk(10, OP_IRQ, 0, 0, 0),      // R10 not enabled
      mk(9, OP_WR, 14, 8'hC0, 0),   // R9 enable bit 6
      mk(10, OP_IRQ, 0, 0, 1),      // R10
      mk(8, OP_RD, 13, 0, 8'hC0),   // R8 summary bit
      mk(9, OP_RD, 14, 0, 8'hC0),   // R9
      mk(2, OP_TK,  0, 1, 0),       // R2 to 0xFFFF
      mk(2, OP_RD,  5, 0, 8'hFF),   // R2
      mk(2, OP_TK,  0, 1, 0),       // R2 reload
      mk(2, OP_RD,  4, 0, 8'h03),   // R2 reloaded latch, clears flag
      mk(5, OP_IRQ, 0, 0, 0),       // R5 read of 4 dropped the flag
      mk(5, OP_RD, 13, 0, 8'h00),   // R5
      mk(3, OP_WR, 11, 8'h00, 0),   // R3 leave continuous mode
      mk(6, OP_WR,  8, 8'h02, 0),   // R6
      mk(6, OP_WR,  9, 8'h00, 0),   // R6 load 0x0002
      mk(6, OP_RD,  9, 0, 8'h00),   // R6
      mk(6, OP_RD,  8, 0, 8'h02),   // R6
      mk(6, OP_TK,  0, 2, 0),       // R6 reach zero
      mk(6, OP_RD, 13, 0, 8'h20),   // R6 flag bit 5
      mk(10, OP_IRQ, 0, 0, 0),      // R10
      mk(9, OP_WR, 14, 8'hA0, 0),   // R9 enable bit 5
      mk(8, OP_RD, 13, 0, 8'hA0),   // R8
      mk(10, OP_IRQ, 0, 0, 0),      // R10 timer 2 never drives the pin
      mk(6, OP_RD,  8, 0, 8'h00),   // R6 clears bit 5
      mk(6, OP_RD, 13, 0, 8'h00),   // R6
      mk(6, OP_TK,  0, 1, 0),       // R6 wrap
      mk(6, OP_RD,  9, 0, 8'hFF),   // R6
      mk(3, OP_RD, 13, 0, 8'h00)    // R3 timer 1 hit zero outside continuous mode
   };

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] idx, input logic [7:0] d);
      @(negedge clk);
      addr = mk_addr(idx); wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] idx, input logic [7:0] exp, input string tag);
      logic [7:0] got;
      @(negedge clk);
      addr = mk_addr(idx); rd_en = 1'b1;
      #1 got = rdata;
      check(tag, got, exp);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tk(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic pulse_strobe();
      @(negedge clk); strobe = 1'b1;
      @(negedge clk); strobe = 1'b0;
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk);
      check(tag, {7'b0, irq}, {7'b0, exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rd(4, 8'hFF, "R11 t1 cnt lo");
      rd(5, 8'hFF, "R11 t1 cnt hi");
      rd(6, 8'hFF, "R11 t1 latch lo");
      rd(7, 8'hFF, "R11 t1 latch hi");
      rd(9, 8'hFF, "R11 t2 cnt hi");
      rd(13, 8'h00, "R11 flags");
      rd(14, 8'h80, "R11 enable");
      chk_irq(1'b0, "R11 irq");
      wr(9, 8'h12);
      rd(8, 8'h00, "R11 t2 low load byte");
      rd(9, 8'h12, "R6 t2 load high");

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [25:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d vec%0d", v[25:22], i);
         case (v[21:20])
            OP_WR:  wr(v[19:16], v[15:8]);
            OP_RD:  rd(v[19:16], v[7:0], tag);
            OP_TK:  tk(int'(v[15:8]));
            default: chk_irq(v[0], tag);
         endcase
      end

      // R7 shift byte and strobe (enables now 0x60)
      wr(10, 8'h5A);
      pulse_strobe();
      rd(13, 8'h04, "R7 strobe sets bit 2");
      chk_irq(1'b0, "R10 shift not enabled");
      wr(14, 8'h84);
      chk_irq(1'b1, "R10 shift enabled");
      rd(13, 8'h84, "R8 summary");
      rd(10, 8'h5A, "R7 shift readback");
      chk_irq(1'b0, "R7 read cleared flag");
      rd(13, 8'h00, "R7 flag cleared");

      // R8 write-one-to-clear
      pulse_strobe();
      wr(13, 8'h00);
      rd(13, 8'h84, "R8 zero write keeps flag");
      wr(13, 8'h7B);
      rd(13, 8'h84, "R8 other bits keep flag");
      wr(13, 8'h04);
      rd(13, 8'h00, "R8 one clears flag");

      // R9 clear protocol
      wr(14, 8'h04);
      rd(14, 8'hE0, "R9 clear bit 2");
      pulse_strobe();
      chk_irq(1'b0, "R9 disabled source");
      rd(13, 8'h04, "R9 no summary");
      wr(13, 8'h04);

      // R4 register 7 and period
      wr(11, 8'h40);
      wr(6, 8'h02);
      wr(5, 8'h00);
      tk(2);
      rd(13, 8'hC0, "R3 t1 flag");
      wr(7, 8'h00);
      rd(13, 8'h00, "R4 reg 7 clears flag");
      rd(4, 8'h00, "R4 reg 7 no reload");
      tk(2);
      rd(4, 8'h02, "R2 reload after all-ones");
      tk(1);
      rd(13, 8'h00, "R2 mid period");
      tk(1);
      rd(13, 8'hC0, "R2 period latch+2");
      rd(5, 8'h00, "R5 cnt hi");
      rd(13, 8'hC0, "R5 reg 5 read keeps flag");
      chk_irq(1'b1, "R10 t1 irq");
      wr(5, 8'h00);
      rd(13, 8'h00, "R4 reg 5 clears flag");
      chk_irq(1'b0, "R10 t1 irq dropped");
      wr(4, 8'h07);
      rd(4, 8'h02, "R4 reg 4 leaves counter");
      rd(6, 8'h07, "R4 reg 4 sets latch lo");
      rd(7, 8'h00, "R4 latch hi");

      // R1 plain storage and address decode
      wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h33); wr(3, 8'h44);
      wr(12, 8'h55); wr(15, 8'h66);
      rd(0, 8'h11, "R1 idx0");
      rd(1, 8'h22, "R1 idx1");
      rd(2, 8'h33, "R1 idx2");
      rd(3, 8'h44, "R1 idx3");
      rd(11, 8'h40, "R1 idx11");
      rd(12, 8'h55, "R1 idx12");
      rd(15, 8'h66, "R1 idx15");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule